// File: doc/BRIEF.md
# B-Channel HDLC Word FIFO Controller

This block is the host-facing side of one B-channel framing engine. Software configures it with a single 32-bit control word. The command byte sits in bits 7:0, the transmit chunk length in bits 15:8 and the line mode in bits 23:16. Frame data moves through 32-bit word streams, with the lowest byte first. The transmit side works a chunk at a time. The host loads one chunk of at most 32 bytes into the transmit pool. The block then plays the chunk out, one byte at a time, to the serial side. The receive side gathers line bytes into a 32-byte pool. It hands the pool to the host when the pool fills or when a frame ends.

Events are latched in a status word and drive a level interrupt. There are three events: transmit pool free, transmit underrun and receive pool ready. The status word also carries the received chunk length, the frame-end flag, the CRC and abort summary, and a sticky receive overrun flag. Either direction is recovered by holding its reset bit in the command byte and then clearing it.

The two streams use valid/ready. The host word streams obey normal back-pressure, so a word moves only on a cycle where valid and ready are both high. The serial transmit byte stream also moves on valid and ready. The serial receive line has no back-pressure: a byte that cannot be stored is treated as an overrun, not stalled.

Top module: `bch_hdlc_fifo`

## Requirements
- R1: A control write loads the command from bits 7:0, the chunk length from bits 15:8 and the mode from bits 23:16. Mode bit 1 selects transparent operation and takes precedence over mode bit 0, which selects framed operation. With neither bit set, received line bytes are ignored and `line_tx_valid` stays low.
- R2: A chunk length of 0, or of 32 or more, means 32 bytes; any other value is the exact byte count. The host writes ceil(length/4) words. The block sends exactly that many bytes, lowest byte of each word first.
- R3: `tx_wready` is low in four cases: while command bit 7 (transmit reset) is held, while a chunk is being sent, after an underrun, and in any cycle with `ctrl_we` high.
- R4: `line_tx_last` is high only with the final byte of a chunk, and only in framed mode. That chunk's control write must have had command bit 0 set.
- R5: When the final byte of a chunk is taken, status bit 7 (transmit pool free) is set.
- R6: An underrun sets status bit 6 and halts loading until command bit 7 is pulsed. It occurs when the line is ready and no chunk is in progress, provided the block is in transparent mode, or in framed mode after a chunk that did not end the frame. In transparent mode an idle line receives 8'hFF.
- R7: A received chunk completes at 32 bytes, or at a byte marked frame end (framed mode only). Completion sets status bit 5. Bits 13:8 give the byte count, with 0 meaning 32. Bit 0 flags frame end. Bits 3:1 are {abort, not abort, CRC good}, so a good frame reads 3'b011; they are zero for a chunk that does not end a frame.
- R8: A completed receive chunk is offered as ceil(count/4) words on `rx_rvalid` and `rx_rdata`. Bytes are packed lowest first and unused bytes are zero. A word is held stable until the host takes it.
- R9: A line byte that arrives while any word of a chunk is unread is an overrun. It sets status bit 4 and status bit 5 and discards the chunk. Later bytes are dropped until command bit 5 (receive reset) is pulsed, which clears bit 4.
- R10: A status read clears bits 7, 6 and 5. An event in the same cycle leaves its bit set. `irq` is high exactly when any of those three bits is set.
- R11: Status bits 31:24 hold the 4-bit version in their low nibble. After reset the status word holds only the version, `irq` is low, and both streams are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: command, chunk length, mode |
| stat_rd | input | 1 | Status read strobe, clears event bits |
| stat_rdata | output | 32 | Status word |
| irq | output | 1 | Any event bit pending |
| tx_wvalid | input | 1 | Host transmit word valid |
| tx_wdata | input | 32 | Host transmit word |
| tx_wready | output | 1 | Transmit pool accepts a word |
| rx_rvalid | output | 1 | Receive word available |
| rx_rdata | output | 32 | Receive word |
| rx_rready | input | 1 | Host takes the receive word |
| line_tx_valid | output | 1 | Serial byte available |
| line_tx_data | output | 8 | Serial byte |
| line_tx_last | output | 1 | Byte ends the frame |
| line_tx_ready | input | 1 | Serial side takes a byte |
| line_rx_valid | input | 1 | Received line byte strobe |
| line_rx_data | input | 8 | Received line byte |
| line_rx_end | input | 1 | Byte closes a frame |
| line_rx_crc_ok | input | 1 | Frame CRC good (with end) |
| line_rx_abort | input | 1 | Frame aborted (with end) |

## Verification
The assertions assume the host keeps `tx_wdata` and `tx_wvalid` steady until the word is taken. They also assume `line_rx_end`, `line_rx_crc_ok` and `line_rx_abort` only have meaning together with `line_rx_valid`. The stability property on `rx_rdata` holds only while no control write and no line byte can disturb the pending chunk. The stimulus keeps to these conditions. It holds `line_tx_ready` low while a chunk is loading, except where an underrun is the intent. It drains each receive chunk before sending the next line byte, except in the overrun case.

// File: rtl/bch_fifo_pkg.sv
package bch_fifo_pkg;
  localparam int CMD_EOF   = 0;
  localparam int CMD_RXRST = 5;
  localparam int CMD_TXRST = 7;
  localparam int MODE_FRAMED = 0;
  localparam int MODE_RAW    = 1;

  typedef enum logic [1:0] {LINE_OFF, LINE_FRAMED, LINE_RAW} line_mode_e;

  function automatic line_mode_e decode_mode(input logic [7:0] m);
    if (m[MODE_RAW])    return LINE_RAW;
    if (m[MODE_FRAMED]) return LINE_FRAMED;
    return LINE_OFF;
  endfunction
endpackage

// File: rtl/bch_tx_pool.sv
module bch_tx_pool
  import bch_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txrst,
  input  line_mode_e  mode,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_len,
  input  logic        cfg_eof,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        evt_pool,
  output logic        evt_under
);
  localparam int WORDS = DEPTH / 4;
  localparam int WIDX  = $clog2(WORDS);
  localparam int LENW  = $clog2(DEPTH) + 1;
  localparam logic [LENW-1:0] FULL  = LENW'(DEPTH);
  localparam logic [7:0]      FULL8 = 8'(DEPTH);

  logic [31:0]     mem [WORDS];
  logic [LENW-1:0] nxt_len, cur_len, bidx;
  logic [WIDX-1:0] wcnt, last_idx;
  logic            nxt_eof, cur_eof, busy, in_frame, halted;
  logic [LENW-1:0] req_len, nxt_words;
  logic [31:0]     cur_word;
  logic            raw, framed, fire, last_byte;

  assign raw       = (mode == LINE_RAW);
  assign framed    = (mode == LINE_FRAMED);
  assign req_len   = (cfg_len == 8'd0 || cfg_len >= FULL8) ? FULL : cfg_len[LENW-1:0];
  assign nxt_words = (nxt_len + LENW'(3)) >> 2;
  assign last_idx  = WIDX'(nxt_words - LENW'(1));

  assign in_ready  = !txrst && !busy && !halted && !cfg_we;
  assign out_valid = !txrst && (busy || raw);
  assign cur_word  = mem[bidx[WIDX+1:2]];
  assign out_data  = busy ? cur_word[8*bidx[1:0] +: 8] : 8'hFF;
  assign last_byte = (bidx == cur_len - LENW'(1));
  assign out_last  = busy && framed && cur_eof && last_byte;
  assign fire      = out_valid && out_ready;
  assign evt_pool  = !txrst && busy && fire && last_byte;
  assign evt_under = !txrst && !busy && !halted && out_ready && (raw || (framed && in_frame));

  always_ff @(posedge clk)
    if (in_valid && in_ready) mem[wcnt] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_len <= FULL; nxt_eof <= 1'b0; cur_len <= FULL; cur_eof <= 1'b0;
      busy <= 1'b0; wcnt <= '0; bidx <= '0; in_frame <= 1'b0; halted <= 1'b0;
    end else begin
      if (cfg_we) begin
        nxt_len <= req_len;
        nxt_eof <= cfg_eof;
      end
      if (txrst) begin
        busy <= 1'b0; wcnt <= '0; bidx <= '0; in_frame <= 1'b0; halted <= 1'b0;
      end else begin
        if (evt_under) halted <= 1'b1;
        if (busy && fire) begin
          if (last_byte) begin
            busy     <= 1'b0;
            bidx     <= '0;
            in_frame <= framed && !cur_eof;
          end else begin
            bidx <= bidx + LENW'(1);
          end
        end
        if (cfg_we) begin
          wcnt <= '0;
        end else if (in_valid && in_ready) begin
          if (wcnt == last_idx) begin
            busy    <= 1'b1;
            wcnt    <= '0;
            cur_len <= nxt_len;
            cur_eof <= nxt_eof;
          end else begin
            wcnt <= wcnt + WIDX'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/bch_rx_pool.sv
module bch_rx_pool
  import bch_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxrst,
  input  line_mode_e  mode,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_end,
  input  logic        in_crc_ok,
  input  logic        in_abort,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready,
  output logic [5:0]  st_cnt,
  output logic        st_end,
  output logic [2:0]  st_fmt,
  output logic        st_over,
  output logic        evt_pool
);
  localparam int WORDS = DEPTH / 4;
  localparam int WIDX  = $clog2(WORDS);
  localparam int LENW  = $clog2(DEPTH) + 1;
  localparam logic [LENW-1:0] FULL = LENW'(DEPTH);

  logic [31:0]     mem [WORDS];
  logic [LENW-1:0] wp, plen, newlen;
  logic [WIDX-1:0] rp, plast;
  logic            pend, take, term, overrun, store, done;

  assign take     = in_valid && (mode != LINE_OFF) && !rxrst && !st_over;
  assign term     = (mode == LINE_FRAMED) && in_end;
  assign newlen   = wp + LENW'(1);
  assign overrun  = take && pend;
  assign store    = take && !pend;
  assign done     = store && (newlen == FULL || term);
  assign evt_pool = overrun || done;
  assign out_valid = pend;
  assign out_data  = mem[rp];
  assign plast     = WIDX'(((plen + LENW'(3)) >> 2) - LENW'(1));

  always_ff @(posedge clk)
    if (store) begin
      if (wp[1:0] == 2'd0) mem[wp[WIDX+1:2]] <= {24'h0, in_data};
      else                 mem[wp[WIDX+1:2]][8*wp[1:0] +: 8] <= in_data;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; plen <= '0; rp <= '0; pend <= 1'b0; st_over <= 1'b0;
      st_cnt <= '0; st_end <= 1'b0; st_fmt <= '0;
    end else if (rxrst) begin
      wp <= '0; rp <= '0; pend <= 1'b0; st_over <= 1'b0;
      st_cnt <= '0; st_end <= 1'b0; st_fmt <= '0;
    end else begin
      if (overrun) begin
        st_over <= 1'b1;
        pend    <= 1'b0;
      end else if (pend && out_ready) begin
        if (rp == plast) pend <= 1'b0;
        else             rp   <= rp + WIDX'(1);
      end
      if (store) begin
        if (done) begin
          pend   <= 1'b1;
          plen   <= newlen;
          wp     <= '0;
          rp     <= '0;
          st_cnt <= (newlen == FULL) ? 6'd0 : 6'(newlen);
          st_end <= term;
          st_fmt <= term ? {in_abort, !in_abort, in_crc_ok} : 3'b000;
        end else begin
          wp <= newlen;
        end
      end
    end
  end
endmodule

// File: rtl/bch_hdlc_fifo.sv
module bch_hdlc_fifo
  import bch_fifo_pkg::*;
#(
  parameter int         DEPTH   = 32,
  parameter logic [3:0] VERSION = 4'h3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        stat_rd,
  output logic [31:0] stat_rdata,
  output logic        irq,
  input  logic        tx_wvalid,
  input  logic [31:0] tx_wdata,
  output logic        tx_wready,
  output logic        rx_rvalid,
  output logic [31:0] rx_rdata,
  input  logic        rx_rready,
  output logic        line_tx_valid,
  output logic [7:0]  line_tx_data,
  output logic        line_tx_last,
  input  logic        line_tx_ready,
  input  logic        line_rx_valid,
  input  logic [7:0]  line_rx_data,
  input  logic        line_rx_end,
  input  logic        line_rx_crc_ok,
  input  logic        line_rx_abort
);
  logic [7:0] cmd_q, mode_q;
  line_mode_e mode;
  logic       flag_xpr, flag_xdu, flag_rpr;
  logic       evt_tx_pool, evt_under, evt_rx_pool;
  logic [5:0] st_cnt;
  logic [2:0] st_fmt;
  logic       st_end, st_over;

  assign mode = decode_mode(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; mode_q <= '0;
    end else if (ctrl_we) begin
      cmd_q  <= ctrl_wdata[7:0];
      mode_q <= ctrl_wdata[23:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_xpr <= 1'b0; flag_xdu <= 1'b0; flag_rpr <= 1'b0;
    end else begin
      flag_xpr <= evt_tx_pool || (flag_xpr && !stat_rd);
      flag_xdu <= evt_under   || (flag_xdu && !stat_rd);
      flag_rpr <= evt_rx_pool || (flag_rpr && !stat_rd);
    end
  end

  bch_tx_pool #(.DEPTH(DEPTH)) u_tx (
    .clk, .rst_n,
    .txrst(cmd_q[CMD_TXRST]), .mode,
    .cfg_we(ctrl_we), .cfg_len(ctrl_wdata[15:8]), .cfg_eof(ctrl_wdata[CMD_EOF]),
    .in_valid(tx_wvalid), .in_data(tx_wdata), .in_ready(tx_wready),
    .out_valid(line_tx_valid), .out_data(line_tx_data), .out_last(line_tx_last),
    .out_ready(line_tx_ready),
    .evt_pool(evt_tx_pool), .evt_under(evt_under)
  );

  bch_rx_pool #(.DEPTH(DEPTH)) u_rx (
    .clk, .rst_n,
    .rxrst(cmd_q[CMD_RXRST]), .mode,
    .in_valid(line_rx_valid), .in_data(line_rx_data), .in_end(line_rx_end),
    .in_crc_ok(line_rx_crc_ok), .in_abort(line_rx_abort),
    .out_valid(rx_rvalid), .out_data(rx_rdata), .out_ready(rx_rready),
    .st_cnt, .st_end, .st_fmt, .st_over,
    .evt_pool(evt_rx_pool)
  );

  assign stat_rdata = {4'h0, VERSION, 8'h00, 2'b00, st_cnt,
                       flag_xpr, flag_xdu, flag_rpr, st_over, st_fmt, st_end};
  assign irq = flag_xpr || flag_xdu || flag_rpr;
endmodule

// File: rtl/bch_hdlc_fifo_chk.sv
module bch_hdlc_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_we,
  input logic [31:0] ctrl_wdata,
  input logic        stat_rd,
  input logic [31:0] stat_rdata,
  input logic        irq,
  input logic        tx_wvalid,
  input logic [31:0] tx_wdata,
  input logic        tx_wready,
  input logic        rx_rvalid,
  input logic [31:0] rx_rdata,
  input logic        rx_rready,
  input logic        line_tx_valid,
  input logic [7:0]  line_tx_data,
  input logic        line_tx_last,
  input logic        line_tx_ready,
  input logic        line_rx_valid,
  input logic [7:0]  line_rx_data,
  input logic        line_rx_end,
  input logic        line_rx_crc_ok,
  input logic        line_rx_abort
);
  assert_reset_blocks_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[7]) |=> !tx_wready);

  assert_last_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_tx_last |-> line_tx_valid);

  assert_pool_free_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[7]) |-> $past(line_tx_valid && line_tx_ready));

  assert_underrun_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[6]) |-> $past(line_tx_ready));

  assert_rx_event_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[5]) |-> $past(line_rx_valid));

  assert_rx_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rvalid && !rx_rready && !ctrl_we && !line_rx_valid) |=> (rx_rvalid && $stable(rx_rdata)));

  assert_overrun_hides_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[4] |-> !rx_rvalid);
endmodule

bind bch_hdlc_fifo bch_hdlc_fifo_chk u_bch_hdlc_fifo_chk (.*);

// File: tb/test_bch_hdlc_fifo.sv
`timescale 1ns/1ps
module test_bch_hdlc_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0; logic [31:0] ctrl_wdata = '0;
  logic stat_rd = 0;
  logic [31:0] stat_rdata; logic irq;
  logic tx_wvalid = 0; logic [31:0] tx_wdata = '0; logic tx_wready;
  logic rx_rvalid; logic [31:0] rx_rdata; logic rx_rready = 0;
  logic line_tx_valid; logic [7:0] line_tx_data; logic line_tx_last; logic line_tx_ready = 0;
  logic line_rx_valid = 0; logic [7:0] line_rx_data = '0;
  logic line_rx_end = 0, line_rx_crc_ok = 0, line_rx_abort = 0;

  always #4 clk = ~clk;

  bch_hdlc_fifo i_bch_hdlc_fifo (.*);

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_cmd = 0, m_mode = 0;
  int          nxt_len = 32; bit nxt_xme = 0;
  logic [7:0]  txq[$]; logic [31:0] loadq[$];
  bit          cur_xme = 0, in_frame = 0, halted = 0;
  logic [7:0]  acc[$]; logic [31:0] pend[$];
  bit          rdo = 0, rme = 0; int cnt = 0; logic [2:0] fst = 0;
  bit          xpr = 0, xdu = 0, rpr = 0;
  bit p_wready, p_tv, p_tl, p_rv, p_irq; logic [7:0] p_td; logic [31:0] p_rd, p_stat;

  task automatic predict();
    bit xrs, trans, hdlc, sending;
    xrs = m_cmd[7]; trans = m_mode[1]; hdlc = m_mode[0] && !m_mode[1];
    sending = txq.size() != 0;
    p_wready = !xrs && !sending && !halted && !ctrl_we;
    p_tv = !xrs && (sending || trans);
    p_td = sending ? txq[0] : 8'hFF;
    p_tl = sending && hdlc && cur_xme && txq.size() == 1;
    p_rv = pend.size() != 0;
    p_rd = p_rv ? pend[0] : 32'h0;
    p_stat = {4'h0, 4'h3, 8'h0, 2'b0, 6'(cnt), xpr, xdu, rpr, rdo, fst, rme};
    p_irq = xpr || xdu || rpr;
  endtask

  task automatic model_step();
    bit xrs, rrs, trans, hdlc, sending, fire, ev_xpr, ev_xdu, ev_rpr, pre_pend;
    predict();
    xrs = m_cmd[7]; rrs = m_cmd[5]; trans = m_mode[1]; hdlc = m_mode[0] && !m_mode[1];
    sending = txq.size() != 0; fire = p_tv && line_tx_ready;
    ev_xpr = 0; ev_xdu = 0; ev_rpr = 0;
    if (xrs) begin
      txq.delete(); loadq.delete(); in_frame = 0; halted = 0;
    end else begin
      if (sending && fire) begin
        void'(txq.pop_front());
        if (txq.size() == 0) begin ev_xpr = 1; in_frame = hdlc && !cur_xme; end
      end else if (!sending && !halted && line_tx_ready && (trans || (hdlc && in_frame))) begin
        halted = 1; ev_xdu = 1;
      end
      if (ctrl_we) loadq.delete();
      else if (tx_wvalid && p_wready) begin
        loadq.push_back(tx_wdata);
        if (loadq.size() == (nxt_len + 3) / 4) begin
          for (int b = 0; b < nxt_len; b++) txq.push_back(loadq[b/4][8*(b%4) +: 8]);
          cur_xme = nxt_xme; loadq.delete();
        end
      end
    end
    if (rrs) begin
      acc.delete(); pend.delete(); rdo = 0; cnt = 0; rme = 0; fst = 0;
    end else begin
      pre_pend = pend.size() != 0;
      if (pre_pend && rx_rready) void'(pend.pop_front());
      if (line_rx_valid && (m_mode[0] || m_mode[1]) && !rdo) begin
        if (pre_pend) begin
          rdo = 1; pend.delete(); ev_rpr = 1;
        end else begin
          acc.push_back(line_rx_data);
          if (acc.size() == 32 || (hdlc && line_rx_end)) begin
            for (int w = 0; w < (acc.size() + 3) / 4; w++) begin
              logic [31:0] word = 0;
              for (int k = 0; k < 4; k++) if (4*w + k < acc.size()) word[8*k +: 8] = acc[4*w + k];
              pend.push_back(word);
            end
            cnt = acc.size() % 32; rme = hdlc && line_rx_end;
            fst = rme ? {line_rx_abort, !line_rx_abort, line_rx_crc_ok} : 3'b000;
            ev_rpr = 1; acc.delete();
          end
        end
      end
    end
    if (ctrl_we) begin
      nxt_len = (ctrl_wdata[15:8] == 0 || ctrl_wdata[15:8] >= 32) ? 32 : int'(ctrl_wdata[15:8]);
      nxt_xme = ctrl_wdata[0]; m_cmd = ctrl_wdata[7:0]; m_mode = ctrl_wdata[23:16];
    end
    if (stat_rd) begin xpr = 0; xdu = 0; rpr = 0; end
    if (ev_xpr) xpr = 1;
    if (ev_xdu) xdu = 1;
    if (ev_rpr) rpr = 1;
  endtask

  always @(posedge clk) if (rst_n) model_step();

  always @(negedge clk) if (rst_n) begin
    predict();
    chk("R3", tx_wready, p_wready);
    chk("R2", line_tx_valid, p_tv);
    if (p_tv) chk("R2", line_tx_data, p_td);
    chk("R4", line_tx_last, p_tl);
    chk("R8", rx_rvalid, p_rv);
    if (p_rv) chk("R8", rx_rdata, p_rd);
    chk("R5", stat_rdata[7], p_stat[7]);
    chk("R6", stat_rdata[6], p_stat[6]);
    chk("R7", {stat_rdata[13:8], stat_rdata[5], stat_rdata[3:0]},
              {p_stat[13:8], p_stat[5], p_stat[3:0]});
    chk("R9", stat_rdata[4], p_stat[4]);
    chk("R11", stat_rdata[31:14], p_stat[31:14]);
    chk("R10", irq, p_irq);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr_ctrl(input logic [7:0] c, input logic [7:0] len, input logic [7:0] m);
    ctrl_we = 1; ctrl_wdata = {8'h00, m, len, c}; step(); ctrl_we = 0;
  endtask

  task automatic rd_stat(); stat_rd = 1; step(); stat_rd = 0; endtask

  task automatic load_chunk(input int nbytes, input logic [7:0] seed);
    for (int w = 0; w < (nbytes + 3) / 4; w++) begin
      bit ok;
      tx_wvalid = 1;
      for (int k = 0; k < 4; k++) tx_wdata[8*k +: 8] = seed + 8'(4*w + k);
      do begin @(negedge clk); ok = tx_wready; step(); end while (!ok);
    end
    tx_wvalid = 0;
  endtask

  task automatic send_line(input int n); line_tx_ready = 1; repeat (n) step(); line_tx_ready = 0; endtask

  task automatic rx_bytes(input int n, input logic [7:0] seed, input bit fin, input bit crc, input bit ab);
    for (int i = 0; i < n; i++) begin
      line_rx_valid = 1; line_rx_data = seed + 8'(i);
      line_rx_end = fin && (i == n - 1); line_rx_crc_ok = crc; line_rx_abort = ab;
      step();
    end
    line_rx_valid = 0; line_rx_end = 0;
  endtask

  task automatic drain_rx(input int n); rx_rready = 1; repeat (n) step(); rx_rready = 0; endtask

  bit finished = 0;
  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    @(negedge clk);
    chk("R11", stat_rdata, 32'h0300_0000);
    chk("R11", {31'b0, irq}, 0);
    chk("R11", {31'b0, line_tx_valid || rx_rvalid}, 0);
    step();
    // framed transmit: 32-byte chunk then 5-byte final chunk
    wr_ctrl(8'hA0, 8'h00, 8'h01);
    wr_ctrl(8'h00, 8'h00, 8'h01);
    load_chunk(32, 8'h10); send_line(32); step();
    @(negedge clk); chk("R5", stat_rdata[7], 1); step();
    rd_stat();
    wr_ctrl(8'h01, 8'd5, 8'h01);
    load_chunk(5, 8'h60); send_line(5); step(); rd_stat();
    // framed underrun mid-frame, recovery by transmit reset
    wr_ctrl(8'h00, 8'd16, 8'h01);
    load_chunk(16, 8'h80); send_line(16);
    send_line(1);
    @(negedge clk); chk("R6", stat_rdata[6], 1); chk("R3", tx_wready, 0); step();
    wr_ctrl(8'h80, 8'h00, 8'h01);
    wr_ctrl(8'h01, 8'd40, 8'h01);
    load_chunk(32, 8'hA0); send_line(32); step(); rd_stat();
    // transparent transmit, eof ignored, idle fill after chunk
    wr_ctrl(8'hA0, 8'h00, 8'h02);
    wr_ctrl(8'h01, 8'h00, 8'h02);
    load_chunk(32, 8'h30); send_line(32);
    line_tx_ready = 1; @(negedge clk); chk("R6", line_tx_data, 8'hFF); step();
    step(); line_tx_ready = 0; step();
    rd_stat();
    wr_ctrl(8'h80, 8'h00, 8'h01); wr_ctrl(8'h00, 8'h00, 8'h01);
    // framed receive: short good frame, then 40-byte aborted frame
    rx_bytes(10, 8'h21, 1, 1, 0); step();
    @(negedge clk); chk("R7", {stat_rdata[13:8], stat_rdata[3:0]}, {6'd10, 4'b0111}); step();
    drain_rx(3); rd_stat();
    rx_bytes(32, 8'h40, 0, 0, 0); step();
    @(negedge clk); chk("R7", stat_rdata[13:8], 0); step();
    drain_rx(8);
    rx_bytes(8, 8'h70, 1, 0, 1); drain_rx(2); rd_stat();
    // overrun and receive reset recovery
    rx_bytes(4, 8'h90, 1, 1, 0); rx_bytes(2, 8'h94, 0, 0, 0);
    @(negedge clk); chk("R9", stat_rdata[4], 1); chk("R9", rx_rvalid, 0); step();
    rx_bytes(3, 8'h99, 1, 1, 0);
    wr_ctrl(8'h20, 8'h00, 8'h01); wr_ctrl(8'h00, 8'h00, 8'h01);
    @(negedge clk); chk("R9", stat_rdata[4], 0); step();
    rx_bytes(6, 8'hB0, 1, 1, 0); drain_rx(2); rd_stat();
    // status read coinciding with a receive event
    rx_bytes(2, 8'hC0, 0, 0, 0);
    stat_rd = 1; rx_bytes(1, 8'hC2, 1, 1, 0); stat_rd = 0;
    @(negedge clk); chk("R10", stat_rdata[5], 1); chk("R10", irq, 1); step();
    drain_rx(1); rd_stat();
    // transparent receive: end marks ignored, chunk at 32 bytes
    wr_ctrl(8'h80, 8'h00, 8'h02);
    rx_bytes(16, 8'h05, 1, 1, 0); rx_bytes(16, 8'h15, 1, 0, 0); step();
    @(negedge clk); chk("R7", stat_rdata[0], 0); step();
    drain_rx(8); rd_stat();
    // mode off: line bytes ignored, transmit idle
    wr_ctrl(8'h80, 8'h00, 8'h00); wr_ctrl(8'h00, 8'h00, 8'h00);
    rx_bytes(5, 8'hE0, 1, 1, 0); line_tx_ready = 1; step(); line_tx_ready = 0;
    @(negedge clk);
    chk("R1", rx_rvalid, 0); chk("R1", stat_rdata[5], 0); chk("R1", line_tx_valid, 0);
    step(); step();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule